// File: doc/BRIEF.md
# Auto-Modifying Indirect Pointer Unit

This block gives an instruction indirect access to a 512-word register file through two 9-bit pointers, called pointer A and pointer B. The highest eight register addresses are not storage. When an instruction's destination or source address field names one of these eight aliases, the block uses the current value of the matching pointer as the real address. Depending on which alias was named, it can also step that pointer up or down before or after the access.

The unit sits between instruction decode and the register-file read ports. In the first clock the literal fields are presented together with an instruction-valid strobe. On the following clock the unit presents the resolved effective addresses, which the register file then reads. Resolving in this extra clock leaves the clock period unchanged. A software stack held in the register file falls out of this scheme. A call is a jump-and-save through pointer A with post-decrement, and the matching return is a jump through pointer A with pre-increment. A separate write port loads either pointer directly.

Top module: `ind_ptr_unit`

## Requirements
- R1: After reset both pointers are 0, `eff_valid` is 0 and both effective addresses are 0.
- R2: A field value below 0x1F8 passes through unchanged. One clock after an `instr_valid` cycle, `dst_eff`/`src_eff` hold the fields and `eff_valid` is 1. `eff_valid` is 0 after a cycle without `instr_valid`.
- R3: Aliases live at 0x1F8..0x1FF. Field bit 2 selects the pointer (0 = A, 1 = B). Field bits 1:0 select the mode: 0 = plain use, 1 = use then increment, 2 = use then decrement, 3 = increment then use.
- R4: In post-increment and post-decrement modes, the effective address is the pointer's old value, and the pointer then changes by +1 or -1.
- R5: In pre-increment mode, the pointer and the effective address both equal the old value + 1. In plain mode the pointer is left unchanged.
- R6: All pointer arithmetic wraps modulo 512 (511 + 1 = 0, 0 - 1 = 511).
- R7: When the destination field names one pointer and the source field names the other, both pointers are updated in the same instruction.
- R8: When both fields name the same pointer, the destination's modification is applied first, and the source resolves from the updated value. A post-decrement call through A followed by a pre-increment return through A gives back the same address.
- R9: `ptr_wr_en` loads `ptr_wr_data` into the pointer chosen by `ptr_wr_sel` (0 = A, 1 = B), visible on the next clock. The write overrides any auto-modify of that pointer in the same cycle. Effective addresses in that cycle still resolve from the old values, and the other pointer still auto-modifies.
- R10: Without `instr_valid` and without `ptr_wr_en`, both pointers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | The address fields carry a valid instruction this cycle |
| dst_field | input | 9 | Destination address field |
| src_field | input | 9 | Source address field |
| ptr_wr_en | input | 1 | Direct pointer write strobe |
| ptr_wr_sel | input | 1 | Pointer chosen for the write (0 = A, 1 = B) |
| ptr_wr_data | input | 9 | Value written to the pointer |
| dst_eff | output | 9 | Resolved destination address, one clock after the fields |
| src_eff | output | 9 | Resolved source address, one clock after the fields |
| eff_valid | output | 1 | Effective addresses belong to the previous instruction |
| ptr_a | output | 9 | Current value of pointer A |
| ptr_b | output | 9 | Current value of pointer B |

## Verification
The bound checker watches, on every cycle, the one-clock timing of `eff_valid`, the literal pass-through, the post-increment step with wrap on pointer A, direct writes, and pointer stability when idle. Only the bench's sweeps can show the combined cases. These are every pairing of the eight aliases and literal fields across pointer values that sit on the wrap boundary; the ordering when both fields share a pointer; a write colliding with an auto-modify; and the call/return round trip.

// File: rtl/ind_ptr_pkg.sv
package ind_ptr_pkg;
    typedef enum logic [1:0] {
        PM_PLAIN    = 2'd0,
        PM_POST_INC = 2'd1,
        PM_POST_DEC = 2'd2,
        PM_PRE_INC  = 2'd3
    } ptr_mode_e;

    typedef enum logic {
        PSEL_A = 1'b0,
        PSEL_B = 1'b1
    } ptr_sel_e;
endpackage

// File: rtl/ind_alias_decode.sv
module ind_alias_decode
    import ind_ptr_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic [ADDR_W-1:0] field,
    output logic              hit,
    output ptr_sel_e          sel,
    output ptr_mode_e         mode
);
    // the alias window is the top eight addresses, aligned on eight
    assign hit  = &field[ADDR_W-1:3];
    assign sel  = ptr_sel_e'(field[2]);
    assign mode = ptr_mode_e'(field[1:0]);
endmodule

// File: rtl/ind_ptr_step.sv
module ind_ptr_step
    import ind_ptr_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic [ADDR_W-1:0] cur,
    input  ptr_mode_e         mode,
    output logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] nxt
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    always_comb begin
        addr = cur;
        nxt  = cur;
        unique case (mode)
            PM_PLAIN:    nxt = cur;
            PM_POST_INC: nxt = cur + ONE;
            PM_POST_DEC: nxt = cur - ONE;
            PM_PRE_INC: begin
                nxt  = cur + ONE;
                addr = cur + ONE;
            end
            default:     nxt = cur;
        endcase
    end
endmodule

// File: rtl/ind_ptr_unit.sv
module ind_ptr_unit
    import ind_ptr_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [ADDR_W-1:0] dst_field,
    input  logic [ADDR_W-1:0] src_field,
    input  logic              ptr_wr_en,
    input  logic              ptr_wr_sel,
    input  logic [ADDR_W-1:0] ptr_wr_data,
    output logic [ADDR_W-1:0] dst_eff,
    output logic [ADDR_W-1:0] src_eff,
    output logic              eff_valid,
    output logic [ADDR_W-1:0] ptr_a,
    output logic [ADDR_W-1:0] ptr_b
);
    localparam int NFIELD = 2;

    typedef struct packed {
        logic [ADDR_W-1:0] pa;
        logic [ADDR_W-1:0] pb;
        logic [ADDR_W-1:0] deff;
        logic [ADDR_W-1:0] seff;
        logic              ev;
    } state_t;

    state_t st_q, st_d;

    logic [ADDR_W-1:0] fld    [NFIELD];
    logic              hit    [NFIELD];
    ptr_sel_e          sel    [NFIELD];
    ptr_mode_e         mode   [NFIELD];

    assign fld[0] = dst_field;
    assign fld[1] = src_field;

    for (genvar i = 0; i < NFIELD; i++) begin : g_dec
        ind_alias_decode #(.ADDR_W(ADDR_W)) u_dec (
            .field (fld[i]),
            .hit   (hit[i]),
            .sel   (sel[i]),
            .mode  (mode[i])
        );
    end

    // destination resolves first on the registered pointers
    logic [ADDR_W-1:0] d_cur, d_addr, d_nxt;
    logic [ADDR_W-1:0] pa_mid, pb_mid;
    assign d_cur = (sel[0] == PSEL_B) ? st_q.pb : st_q.pa;

    ind_ptr_step #(.ADDR_W(ADDR_W)) u_dstep (
        .cur  (d_cur),
        .mode (mode[0]),
        .addr (d_addr),
        .nxt  (d_nxt)
    );

    assign pa_mid = (hit[0] && sel[0] == PSEL_A) ? d_nxt : st_q.pa;
    assign pb_mid = (hit[0] && sel[0] == PSEL_B) ? d_nxt : st_q.pb;

    // source resolves on the values left by the destination
    logic [ADDR_W-1:0] s_cur, s_addr, s_nxt;
    assign s_cur = (sel[1] == PSEL_B) ? pb_mid : pa_mid;

    ind_ptr_step #(.ADDR_W(ADDR_W)) u_sstep (
        .cur  (s_cur),
        .mode (mode[1]),
        .addr (s_addr),
        .nxt  (s_nxt)
    );

    always_comb begin
        st_d    = st_q;
        st_d.ev = instr_valid;
        if (instr_valid) begin
            st_d.deff = hit[0] ? d_addr : dst_field;
            st_d.seff = hit[1] ? s_addr : src_field;
            st_d.pa   = (hit[1] && sel[1] == PSEL_A) ? s_nxt : pa_mid;
            st_d.pb   = (hit[1] && sel[1] == PSEL_B) ? s_nxt : pb_mid;
        end
        if (ptr_wr_en) begin
            if (ptr_wr_sel) st_d.pb = ptr_wr_data;
            else            st_d.pa = ptr_wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dst_eff   = st_q.deff;
    assign src_eff   = st_q.seff;
    assign eff_valid = st_q.ev;
    assign ptr_a     = st_q.pa;
    assign ptr_b     = st_q.pb;
endmodule

// File: rtl/ind_ptr_unit_checker.sv
module ind_ptr_unit_checker #(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_valid,
    input logic [ADDR_W-1:0] dst_field,
    input logic [ADDR_W-1:0] src_field,
    input logic              ptr_wr_en,
    input logic              ptr_wr_sel,
    input logic [ADDR_W-1:0] ptr_wr_data,
    input logic [ADDR_W-1:0] dst_eff,
    input logic              eff_valid,
    input logic [ADDR_W-1:0] ptr_a,
    input logic [ADDR_W-1:0] ptr_b
);
    localparam logic [ADDR_W-1:0] BASE    = {{(ADDR_W-3){1'b1}}, 3'b000};
    localparam logic [ADDR_W-1:0] A_PINC  = BASE + ADDR_W'(1);

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |=> eff_valid);

    assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> !eff_valid);

    assert_literal_dst_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && dst_field < BASE) |=> dst_eff == $past(dst_field));

    assert_postinc_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && dst_field == A_PINC && src_field < BASE && !ptr_wr_en)
        |=> (ptr_a == $past(ptr_a) + ADDR_W'(1)) && (dst_eff == $past(ptr_a)));

    assert_write_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_wr_en && !ptr_wr_sel) |=> ptr_a == $past(ptr_wr_data));

    assert_write_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_wr_en && ptr_wr_sel) |=> ptr_b == $past(ptr_wr_data));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr_valid && !ptr_wr_en) |=> ($stable(ptr_a) && $stable(ptr_b)));
endmodule

bind ind_ptr_unit ind_ptr_unit_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .dst_field   (dst_field),
    .src_field   (src_field),
    .ptr_wr_en   (ptr_wr_en),
    .ptr_wr_sel  (ptr_wr_sel),
    .ptr_wr_data (ptr_wr_data),
    .dst_eff     (dst_eff),
    .eff_valid   (eff_valid),
    .ptr_a       (ptr_a),
    .ptr_b       (ptr_b)
);

// File: tb/ind_ptr_unit_test.sv
module ind_ptr_unit_test;
    localparam int AW = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          instr_valid = 1'b0;
    logic [AW-1:0] dst_field = '0;
    logic [AW-1:0] src_field = '0;
    logic          ptr_wr_en = 1'b0;
    logic          ptr_wr_sel = 1'b0;
    logic [AW-1:0] ptr_wr_data = '0;
    logic [AW-1:0] dst_eff, src_eff, ptr_a, ptr_b;
    logic          eff_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    ind_ptr_unit #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid),
        .dst_field(dst_field), .src_field(src_field),
        .ptr_wr_en(ptr_wr_en), .ptr_wr_sel(ptr_wr_sel), .ptr_wr_data(ptr_wr_data),
        .dst_eff(dst_eff), .src_eff(src_eff), .eff_valid(eff_valid),
        .ptr_a(ptr_a), .ptr_b(ptr_b)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // one field against pointer values: returns address, updates pa/pb
    task automatic resolve(input int f, inout int pa, inout int pb, output int addr);
        int p, m;
        if (f < 504) begin
            addr = f;
            return;
        end
        m = f % 4;
        p = ((f - 504) >= 4) ? pb : pa;
        case (m)
            0: addr = p;
            1: begin addr = p; p = (p + 1) % 512; end
            2: begin addr = p; p = (p + 511) % 512; end
            default: begin p = (p + 1) % 512; addr = p; end
        endcase
        if ((f - 504) >= 4) pb = p; else pa = p;
    endtask

    task automatic load(input int sel, input int val);
        @(negedge clk);
        ptr_wr_en = 1'b1; ptr_wr_sel = sel[0]; ptr_wr_data = val[AW-1:0];
        @(negedge clk);
        ptr_wr_en = 1'b0;
    endtask

    task automatic issue(input int d, input int s);
        @(negedge clk);
        instr_valid = 1'b1; dst_field = d[AW-1:0]; src_field = s[AW-1:0];
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    initial begin : stim
        int fl [11] = '{0, 85, 503, 504, 505, 506, 507, 508, 509, 510, 511};
        int pv [4][2] = '{'{0, 0}, '{511, 511}, '{5, 200}, '{100, 100}};
        int pa, pb, ed, es;

        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ptr_a", ptr_a, 0);
        check("R1 ptr_b", ptr_b, 0);
        check("R1 eff_valid", eff_valid, 0);
        check("R1 dst_eff", dst_eff, 0);
        check("R1 src_eff", src_eff, 0);
        rst_n = 1'b1;

        // sweep: R2..R8 over every field pairing and boundary pointer values
        for (int v = 0; v < 4; v++) begin
            for (int i = 0; i < 11; i++) begin
                for (int j = 0; j < 11; j++) begin
                    load(0, pv[v][0]);
                    load(1, pv[v][1]);
                    pa = pv[v][0]; pb = pv[v][1];
                    resolve(fl[i], pa, pb, ed);
                    resolve(fl[j], pa, pb, es);
                    issue(fl[i], fl[j]);
                    check("R2 eff_valid", eff_valid, 1);
                    check("R3/R4/R5 dst_eff", dst_eff, ed);
                    check("R8 src_eff", src_eff, es);
                    check("R7 ptr_a", ptr_a, pa);
                    check("R7 ptr_b", ptr_b, pb);
                    @(negedge clk);
                    check("R2 eff_valid low", eff_valid, 0);
                end
            end
        end

        // R6 explicit wrap: post-inc from 511, post-dec from 0
        load(0, 511); load(1, 0);
        issue(505, 510);
        check("R6 a wraps up", ptr_a, 0);
        check("R6 b wraps down", ptr_b, 511);
        check("R6 dst addr", dst_eff, 511);
        check("R6 src addr", src_eff, 0);

        // R8 stack round trip: call post-dec through A, return pre-inc through A
        load(0, 300);
        issue(506, 12);
        check("R8 call slot", dst_eff, 300);
        check("R8 call ptr", ptr_a, 299);
        issue(507, 12);
        check("R8 return slot", dst_eff, 300);
        check("R8 return ptr", ptr_a, 300);

        // R9 write collides with auto-modify on A; B still modifies
        load(0, 40); load(1, 60);
        @(negedge clk);
        instr_valid = 1'b1; dst_field = 9'd505; src_field = 9'd509;
        ptr_wr_en = 1'b1; ptr_wr_sel = 1'b0; ptr_wr_data = 9'd77;
        @(negedge clk);
        instr_valid = 1'b0; ptr_wr_en = 1'b0;
        check("R9 write wins", ptr_a, 77);
        check("R9 dst from old", dst_eff, 40);
        check("R9 other ptr", ptr_b, 61);
        check("R9 src addr", src_eff, 60);

        // R10 idle hold, fields toggling without valid
        dst_field = 9'd505; src_field = 9'd509;
        repeat (5) @(negedge clk);
        check("R10 hold a", ptr_a, 77);
        check("R10 hold b", ptr_b, 61);
        check("R10 eff kept", dst_eff, 40);

        done = 1'b1;
        summary();
    end
endmodule